// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block is the device-side command front end of a NOR-style flash model. It watches the write cycles on the memory bus, which carry an address, data and a write strobe. It accepts a command only when the command is preceded by a fixed two-write unlock prefix with an exact address and data. When a command sequence completes, the block raises a pulse one clock wide on a dedicated output. For program and sector erase it also holds the captured address, and for program the captured data. The flash array and its timing sit outside the block. An erase engine outside the block reports through `erase_busy` whether an erase is running.

The block also tracks whether reads return array contents or identification words. In identification mode, a read at word offset 0 returns the manufacturer code. Offsets 1, 2 and 3 return the three words of the device code. Any other offset returns zero. In array mode, the read port passes through the word supplied by the external array. Any write that does not match the current step of a sequence drops the decoder back to its idle step without issuing a command.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Synchronous active-high `rst` clears every command pulse, `id_mode`, `suspended`, `rd_valid` and any partly entered sequence.
- R2: The unlock prefix is data AAh written to address 5555h, then data 55h written to address 2AAAh. Only address bits [14:0] and data bits [7:0] are compared.
- R3: The prefix followed by 90h written to 5555h pulses `id_enter_p` and sets `id_mode`, both visible one clock after the third write.
- R4: F0h written to any address pulses `reset_p`, clears `id_mode` and returns the decoder to idle. This holds at every step except the program-data step.
- R5: The prefix, then A0h written to 5555h, then any fourth write pulses `prog_p`. `prog_addr` and `prog_data` then hold that write's full address and data; a data value of F0h at this step is programmed.
- R6: The prefix, 80h to 5555h, the prefix again, then 30h to any address pulses `erase_p`, and `erase_addr` holds that last write's address.
- R7: A write that mismatches the expected address or data at a step returns the decoder to idle with no pulse; that write does not itself start a new prefix.
- R8: At the idle step, B0h written to any address pulses `suspend_p` and sets `suspended` only while `erase_busy` is high and `suspended` is low; otherwise it has no effect.
- R9: At the idle step, 30h written to any address pulses `resume_p` and clears `suspended` only while `suspended` is high; otherwise it has no effect.
- R10: One clock after `rd_en`, `rd_valid` is high and `rd_data` holds the read word. In ID mode the word for offsets 0..3 is MFR_ID, DEV_ID0, DEV_ID1, DEV_ID2, and for any other offset it is 0. In array mode the word is `arr_rdata`.
- R11: A read issued in the same cycle as a write that changes `id_mode` uses the mode in force before that write.
- R12: Command pulses last one clock, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; bits [7:0] carry the command byte |
| erase_busy | input | 1 | High while an erase operation is running |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address / ID word offset |
| arr_rdata | input | DATA_W | Word from the array for array-mode reads |
| rd_data | output | DATA_W | Registered read word |
| rd_valid | output | 1 | rd_data is valid |
| id_enter_p | output | 1 | ID mode entry pulse |
| reset_p | output | 1 | Return-to-array-read pulse |
| prog_p | output | 1 | Program command pulse |
| prog_addr | output | ADDR_W | Captured program address |
| prog_data | output | DATA_W | Captured program data |
| erase_p | output | 1 | Sector erase pulse |
| erase_addr | output | ADDR_W | Captured block address |
| suspend_p | output | 1 | Erase suspend pulse |
| resume_p | output | 1 | Erase resume pulse |
| id_mode | output | 1 | 1 = reads return ID words |
| suspended | output | 1 | Erase is held suspended |

## Verification
A read and a mode-changing write can land in the same cycle. This happens with the F0h write that leaves ID mode and with the third write of the ID entry sequence. The bench drives `rd_en` together with each of those writes. It expects the old mode's word: an ID word in the first case and the array word in the second. In both cases `id_mode` must have flipped by the time the read result appears. A follow-up read in the next cycle confirms that the new mode is in effect.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  // Steps of the multi-write command walk
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1_OK,
    ST_KEY2_OK,
    ST_PGM_DATA,
    ST_ERS_ARM,
    ST_ERS_KEY1,
    ST_ERS_KEY2
  } seq_st_t;

  // Only this many low address bits take part in unlock matching
  localparam int CMP_W = 15;
  localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;

  localparam logic [7:0] CB_KEY_A   = 8'hAA;
  localparam logic [7:0] CB_KEY_B   = 8'h55;
  localparam logic [7:0] CB_IDENT   = 8'h90;
  localparam logic [7:0] CB_TO_READ = 8'hF0;
  localparam logic [7:0] CB_PGM     = 8'hA0;
  localparam logic [7:0] CB_ERS_ARM = 8'h80;
  localparam logic [7:0] CB_SECTOR  = 8'h30;
  localparam logic [7:0] CB_HOLD    = 8'hB0;
  localparam logic [7:0] CB_GO      = 8'h30;

  // Combinational command recognition from the sequencer
  typedef struct packed {
    logic ident;
    logic to_read;
    logic pgm;
    logic ers;
    logic hold;
    logic go;
  } hit_t;

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CMP_W-1:0] addr_lo,
  input  logic [7:0]       cmd,
  output hit_t             hit
);

  seq_st_t st_q, st_d;
  logic    at_a, at_b, key_a, key_b;

  assign at_a  = (addr_lo == KEY_ADDR_A);
  assign at_b  = (addr_lo == KEY_ADDR_B);
  assign key_a = at_a && (cmd == CB_KEY_A);
  assign key_b = at_b && (cmd == CB_KEY_B);

  always_comb begin
    st_d = st_q;
    hit  = '0;
    if (wr_en) begin
      // any mismatch falls back to idle unless a branch says otherwise
      st_d = ST_IDLE;
      if (cmd == CB_TO_READ && st_q != ST_PGM_DATA) begin
        hit.to_read = 1'b1;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            if (key_a)                 st_d = ST_KEY1_OK;
            else if (cmd == CB_HOLD)   hit.hold = 1'b1;
            else if (cmd == CB_GO)     hit.go = 1'b1;
          end
          ST_KEY1_OK: begin
            if (key_b) st_d = ST_KEY2_OK;
          end
          ST_KEY2_OK: begin
            if (at_a) begin
              if (cmd == CB_IDENT)        hit.ident = 1'b1;
              else if (cmd == CB_PGM)     st_d = ST_PGM_DATA;
              else if (cmd == CB_ERS_ARM) st_d = ST_ERS_ARM;
            end
          end
          ST_PGM_DATA: hit.pgm = 1'b1;
          ST_ERS_ARM: begin
            if (key_a) st_d = ST_ERS_KEY1;
          end
          ST_ERS_KEY1: begin
            if (key_b) st_d = ST_ERS_KEY2;
          end
          ST_ERS_KEY2: begin
            if (cmd == CB_SECTOR) hit.ers = 1'b1;
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/fcd_ctl.sv
module fcd_ctl
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  hit_t              hit,
  input  logic              erase_busy,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              id_enter_p,
  output logic              reset_p,
  output logic              prog_p,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_p,
  output logic [ADDR_W-1:0] erase_addr,
  output logic              suspend_p,
  output logic              resume_p,
  output logic              id_mode,
  output logic              suspended
);

  logic take_hold, take_go;

  // suspend/resume qualified by erase activity and current hold state
  assign take_hold = hit.hold && erase_busy && !suspended;
  assign take_go   = hit.go && suspended;

  always_ff @(posedge clk) begin
    if (rst) begin
      id_enter_p <= 1'b0;
      reset_p    <= 1'b0;
      prog_p     <= 1'b0;
      erase_p    <= 1'b0;
      suspend_p  <= 1'b0;
      resume_p   <= 1'b0;
      id_mode    <= 1'b0;
      suspended  <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
      erase_addr <= '0;
    end else begin
      id_enter_p <= hit.ident;
      reset_p    <= hit.to_read;
      prog_p     <= hit.pgm;
      erase_p    <= hit.ers;
      suspend_p  <= take_hold;
      resume_p   <= take_go;
      if (hit.ident)        id_mode <= 1'b1;
      else if (hit.to_read) id_mode <= 1'b0;
      if (take_hold)        suspended <= 1'b1;
      else if (take_go)     suspended <= 1'b0;
      if (hit.pgm) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (hit.ers) erase_addr <= wr_addr;
    end
  end

endmodule

// File: rtl/fcd_rdpath.sv
module fcd_rdpath #(
  parameter int              ADDR_W  = 20,
  parameter int              DATA_W  = 16,
  parameter logic [DATA_W-1:0] MFR_ID  = 16'h005A,
  parameter logic [DATA_W-1:0] DEV_ID0 = 16'h2A11,
  parameter logic [DATA_W-1:0] DEV_ID1 = 16'h2A22,
  parameter logic [DATA_W-1:0] DEV_ID2 = 16'h2A33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              id_mode,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int ID_WORDS = 4;
  localparam int OFS_W    = $clog2(ID_WORDS);

  localparam logic [DATA_W-1:0] ID_TAB [ID_WORDS] = '{MFR_ID, DEV_ID0, DEV_ID1, DEV_ID2};

  logic [OFS_W-1:0]  ofs;
  logic              in_range;
  logic [DATA_W-1:0] id_word;

  assign ofs      = rd_addr[OFS_W-1:0];
  assign in_range = (rd_addr[ADDR_W-1:OFS_W] == '0);
  assign id_word  = in_range ? ID_TAB[ofs] : '0;

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_en;
  end

  // data register kept free of reset so it maps onto a RAM/ROM output register
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= id_mode ? id_word : arr_rdata;
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int                ADDR_W  = 20,
  parameter int                DATA_W  = 16,
  parameter logic [DATA_W-1:0] MFR_ID  = 16'h005A,
  parameter logic [DATA_W-1:0] DEV_ID0 = 16'h2A11,
  parameter logic [DATA_W-1:0] DEV_ID1 = 16'h2A22,
  parameter logic [DATA_W-1:0] DEV_ID2 = 16'h2A33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              erase_busy,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              id_enter_p,
  output logic              reset_p,
  output logic              prog_p,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_p,
  output logic [ADDR_W-1:0] erase_addr,
  output logic              suspend_p,
  output logic              resume_p,
  output logic              id_mode,
  output logic              suspended
);

  hit_t hit;

  fcd_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr_lo (wr_addr[CMP_W-1:0]),
    .cmd     (wr_data[7:0]),
    .hit     (hit)
  );

  fcd_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .hit        (hit),
    .erase_busy (erase_busy),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .id_enter_p (id_enter_p),
    .reset_p    (reset_p),
    .prog_p     (prog_p),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .erase_p    (erase_p),
    .erase_addr (erase_addr),
    .suspend_p  (suspend_p),
    .resume_p   (resume_p),
    .id_mode    (id_mode),
    .suspended  (suspended)
  );

  fcd_rdpath #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W),
    .MFR_ID (MFR_ID), .DEV_ID0(DEV_ID0), .DEV_ID1(DEV_ID1), .DEV_ID2(DEV_ID2)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .id_mode   (id_mode),
    .arr_rdata (arr_rdata),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_cmd,
  input logic       erase_busy,
  input logic       rd_en,
  input logic       rd_valid,
  input logic       id_enter_p,
  input logic       reset_p,
  input logic       prog_p,
  input logic       erase_p,
  input logic       suspend_p,
  input logic       resume_p,
  input logic       id_mode,
  input logic       suspended
);

  a_r12_one_pulse: assert property (@(posedge clk) disable iff (rst)
    $onehot0({id_enter_p, reset_p, prog_p, erase_p, suspend_p, resume_p}));

  a_r12_ident_narrow: assert property (@(posedge clk) disable iff (rst)
    id_enter_p |=> !id_enter_p);

  a_r3_ident_sets_mode: assert property (@(posedge clk) disable iff (rst)
    id_enter_p |-> id_mode);

  a_r4_read_clears_mode: assert property (@(posedge clk) disable iff (rst)
    reset_p |-> !id_mode);

  a_r6_erase_needs_sector: assert property (@(posedge clk) disable iff (rst)
    erase_p |-> ($past(wr_en) && $past(wr_cmd) == 8'h30));

  a_r8_hold_gated: assert property (@(posedge clk) disable iff (rst)
    suspend_p |-> ($past(erase_busy) && !$past(suspended) && suspended));

  a_r9_go_gated: assert property (@(posedge clk) disable iff (rst)
    resume_p |-> ($past(suspended) && !suspended));

  a_r10_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

endmodule

bind flash_cmd_decoder fcd_checker u_fcd_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_cmd     (wr_data[7:0]),
  .erase_busy (erase_busy),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .id_enter_p (id_enter_p),
  .reset_p    (reset_p),
  .prog_p     (prog_p),
  .erase_p    (erase_p),
  .suspend_p  (suspend_p),
  .resume_p   (resume_p),
  .id_mode    (id_mode),
  .suspended  (suspended)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam logic [DW-1:0] T_MFR  = 16'h00C7;
  localparam logic [DW-1:0] T_DEV0 = 16'h3101;
  localparam logic [DW-1:0] T_DEV1 = 16'h3202;
  localparam logic [DW-1:0] T_DEV2 = 16'h3303;
  localparam logic [DW-1:0] ARR_W  = 16'hC3C3;

  // expected pulse codes: 0 none, 1 ident, 2 to-read, 3 program,
  // 4 erase, 5 suspend, 6 resume, 7 more than one pulse
  localparam int NV = 48;
  // {addr, data, erase_busy, code, id_mode, suspended}
  localparam logic [41:0] VEC [NV] = '{
    {20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h05555, 16'h0090, 1'b0, 3'd1, 1'b1, 1'b0},
    {20'h12345, 16'h00F0, 1'b0, 3'd2, 1'b0, 1'b0},
    {20'hF5555, 16'hFFAA, 1'b0, 3'd0, 1'b0, 1'b0}, // R2 upper bits ignored
    {20'h7AAAA, 16'h0155, 1'b0, 3'd0, 1'b0, 1'b0}, // R2 upper bits ignored
    {20'h05555, 16'h00A0, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h0ABCD, 16'h00F0, 1'b0, 3'd3, 1'b0, 1'b0}, // F0 as program data
    {20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h05555, 16'h0080, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h0C000, 16'h0030, 1'b0, 3'd4, 1'b0, 1'b0},
    {20'h00000, 16'h00B0, 1'b0, 3'd0, 1'b0, 1'b0}, // suspend without erase
    {20'h00000, 16'h0030, 1'b0, 3'd0, 1'b0, 1'b0}, // resume while not held
    {20'h00123, 16'h00B0, 1'b1, 3'd5, 1'b0, 1'b1},
    {20'h00000, 16'h00B0, 1'b1, 3'd0, 1'b0, 1'b1}, // already held
    {20'h00777, 16'h0030, 1'b1, 3'd6, 1'b0, 1'b0},
    {20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h01AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 1'b0}, // wrong key address
    {20'h05555, 16'h0090, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h05555, 16'h00F0, 1'b0, 3'd2, 1'b0, 1'b0},
    {20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h05555, 16'h00A0, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h00010, 16'h1234, 1'b0, 3'd3, 1'b0, 1'b0},
    {20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 1'b0}, // wrong third write
    {20'h05555, 16'h0090, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h05555, 16'h0080, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h0C000, 16'h0031, 1'b0, 3'd0, 1'b0, 1'b0}, // wrong sector code
    {20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h04555, 16'h0090, 1'b0, 3'd0, 1'b0, 1'b0}, // low-15 address mismatch
    {20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h05555, 16'h0080, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h00000, 16'h00F0, 1'b0, 3'd2, 1'b0, 1'b0}, // F0 mid erase
    {20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h00000, 16'h00B0, 1'b1, 3'd0, 1'b0, 1'b0}, // B0 not at idle step
    {20'h00000, 16'h0030, 1'b0, 3'd0, 1'b0, 1'b0}  // idle, not held
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en, erase_busy, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, arr_rdata;
  logic [DW-1:0] rd_data;
  logic          rd_valid, id_enter_p, reset_p, prog_p, erase_p, suspend_p, resume_p;
  logic          id_mode, suspended;
  logic [AW-1:0] prog_addr, erase_addr;
  logic [DW-1:0] prog_data;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(
    .ADDR_W(AW), .DATA_W(DW),
    .MFR_ID(T_MFR), .DEV_ID0(T_DEV0), .DEV_ID1(T_DEV1), .DEV_ID2(T_DEV2)
  ) i_flash_cmd_decoder (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .erase_busy,
    .rd_en, .rd_addr, .arr_rdata, .rd_data, .rd_valid,
    .id_enter_p, .reset_p, .prog_p, .prog_addr, .prog_data,
    .erase_p, .erase_addr, .suspend_p, .resume_p, .id_mode, .suspended
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] seen_code();
    int n;
    logic [2:0] c;
    n = 0; c = 3'd0;
    if (id_enter_p) begin n++; c = 3'd1; end
    if (reset_p)    begin n++; c = 3'd2; end
    if (prog_p)     begin n++; c = 3'd3; end
    if (erase_p)    begin n++; c = 3'd4; end
    if (suspend_p)  begin n++; c = 3'd5; end
    if (resume_p)   begin n++; c = 3'd6; end
    return (n > 1) ? 3'd7 : c;
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R7";
    endcase
  endfunction

  // one bus cycle: drive at a falling edge, result registered at the rising edge,
  // sampled at the following falling edge
  task automatic cycle(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic busy, input logic re, input logic [AW-1:0] ra);
    wr_en = we; wr_addr = a; wr_data = d; erase_busy = busy;
    rd_en = re; rd_addr = ra;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; erase_busy = 1'b0; rd_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0; arr_rdata = ARR_W;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(seen_code() == 3'd0, "R1 pulses", 32'(seen_code()), 0);
    check(!id_mode && !suspended, "R1 modes", {id_mode, suspended}, 0);
    check(!rd_valid, "R1 rd_valid", 32'(rd_valid), 0);
    rst = 1'b0;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] va;
      logic [DW-1:0] vd;
      logic [2:0]    vc, sc;
      va = VEC[i][41:22]; vd = VEC[i][21:6]; vc = VEC[i][4:2];
      cycle(1'b1, va, vd, VEC[i][5], 1'b0, '0);
      sc = seen_code();
      check(sc != 3'd7, "R12 single pulse", 32'(sc), 32'(vc));
      check(sc == vc, tag_of(vc), 32'(sc), 32'(vc));
      check(id_mode == VEC[i][1], "R3/R4 id_mode", 32'(id_mode), 32'(VEC[i][1]));
      check(suspended == VEC[i][0], "R8/R9 suspended", 32'(suspended), 32'(VEC[i][0]));
      if (vc == 3'd3) begin
        check(prog_addr == va, "R5 prog_addr", 32'(prog_addr), 32'(va));
        check(prog_data == vd, "R5 prog_data", 32'(prog_data), 32'(vd));
      end
      if (vc == 3'd4) check(erase_addr == va, "R6 erase_addr", 32'(erase_addr), 32'(va));
    end
    // R12 pulse is gone one cycle later
    cycle(1'b0, '0, '0, 1'b0, 1'b0, '0);
    check(seen_code() == 3'd0, "R12 width", 32'(seen_code()), 0);

    // R10 ID reads at offsets 0..4
    cycle(1'b1, 20'h05555, 16'h00AA, 1'b0, 1'b0, '0);
    cycle(1'b1, 20'h02AAA, 16'h0055, 1'b0, 1'b0, '0);
    cycle(1'b1, 20'h05555, 16'h0090, 1'b0, 1'b0, '0);
    for (int k = 0; k < 5; k++) begin
      logic [DW-1:0] ex;
      ex = (k == 0) ? T_MFR : (k == 1) ? T_DEV0 : (k == 2) ? T_DEV1 : (k == 3) ? T_DEV2 : '0;
      cycle(1'b0, '0, '0, 1'b0, 1'b1, AW'(k));
      check(rd_valid, "R10 rd_valid", 32'(rd_valid), 1);
      check(rd_data == ex, "R10 id word", 32'(rd_data), 32'(ex));
    end
    cycle(1'b0, '0, '0, 1'b0, 1'b1, 20'h10001); // high offset bits set
    check(rd_data == '0, "R10 out of range", 32'(rd_data), 0);

    // R11 read together with the F0 write that leaves ID mode
    cycle(1'b1, 20'h00000, 16'h00F0, 1'b0, 1'b1, 20'h00002);
    check(rd_data == T_DEV1, "R11 old mode id", 32'(rd_data), 32'(T_DEV1));
    check(!id_mode, "R11 mode left", 32'(id_mode), 0);
    cycle(1'b0, '0, '0, 1'b0, 1'b1, 20'h00002);
    check(rd_data == ARR_W, "R10 array word", 32'(rd_data), 32'(ARR_W));

    // R11 read together with the write that enters ID mode
    cycle(1'b1, 20'h05555, 16'h00AA, 1'b0, 1'b0, '0);
    cycle(1'b1, 20'h02AAA, 16'h0055, 1'b0, 1'b0, '0);
    cycle(1'b1, 20'h05555, 16'h0090, 1'b0, 1'b1, 20'h00001);
    check(rd_data == ARR_W, "R11 old mode array", 32'(rd_data), 32'(ARR_W));
    check(id_mode, "R11 mode entered", 32'(id_mode), 1);
    cycle(1'b0, '0, '0, 1'b0, 1'b1, 20'h00001);
    check(rd_data == T_DEV0, "R11 new mode id", 32'(rd_data), 32'(T_DEV0));

    // R1 reset clears held state and a partial sequence
    cycle(1'b1, 20'h00000, 16'h00B0, 1'b1, 1'b0, '0);
    check(suspended, "R8 held before reset", 32'(suspended), 1);
    cycle(1'b1, 20'h05555, 16'h00AA, 1'b0, 1'b0, '0);
    cycle(1'b1, 20'h02AAA, 16'h0055, 1'b0, 1'b0, '0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!id_mode && !suspended, "R1 reset clears", {id_mode, suspended}, 0);
    cycle(1'b1, 20'h05555, 16'h0090, 1'b0, 1'b0, '0);
    check(seen_code() == 3'd0 && !id_mode, "R1 sequence dropped", 32'(seen_code()), 0);

    finish_run();
  end

endmodule